// File: doc/BRIEF.md
# Segmented Overlap-Add FIR Filter

This block is a streaming FIR filter that works on short segments of the input instead of on a whole block. A producer pushes signed Q1.11 samples into a small input queue. The engine takes a fixed number of samples from that queue into a segment register. It convolves them with a fixed coefficient set, one multiply-accumulate per cycle, and writes the finished results into an output queue that a consumer pops.

Each segment of `SEG` samples yields `SEG+TAPS-1` partial sums. The first `SEG` of them are complete and are emitted. The remaining `TAPS-1` are kept at full precision and become the starting values of the next segment's accumulators. The stream that leaves the block is therefore the same as a direct convolution of the whole input, with no seam between segments.

A four-state controller runs the engine. It starts in idle, then repeats three phases: gather a segment, compute, emit. Each phase waits on the queue it depends on.

Top module: `ola_fir`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_empty` is 1 and `in_full` is 0.
- R2: Output k equals bits [22:11] of the exact sum over j=0..TAPS-1 of h[j]·x[k−j], where x[n] is the n-th accepted input, with x[n]=0 for n<0. The default taps are h0=989, h1=1713, h2=459, h3=−265, all Q1.11, with h0 applied to the newest sample. The result must match across segment boundaries.
- R3: The Q5.22 sum is cut to Q1.11 by dropping its 11 low bits and keeping the next 12 bits. A sum outside the Q1.11 range wraps and does not saturate.
- R4: `in_full` is 1 when the input queue holds `IN_DEPTH` samples. A push while `in_full` is 1 is dropped and does not appear in the output stream.
- R5: When the output queue is full, emission stalls with no sample lost or repeated. The stream resumes in order once the consumer pops again.
- R6: With the input queue empty, the gather phase waits. Gaps between pushes do not change any output value.
- R7: A pop while `out_empty` is 1 has no effect. The output queue stays empty and later outputs are not shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_push | input | 1 | Write `in_data` into the input queue |
| in_data | input | W | Input sample, signed Q1.11 |
| in_full | output | 1 | Input queue full; pushes are dropped |
| out_pop | input | 1 | Remove the head of the output queue |
| out_data | output | W | Head of the output queue, signed Q1.11 |
| out_empty | output | 1 | Output queue holds no sample |

## Verification
On every cycle, the bound assertions check the following:
- The queue occupancies never exceed their depths.
- A full input queue stays full through a rejected push outside the gather phase.
- The emit phase holds its accumulator and state while the output queue is full.
- The gather phase does not advance while the input queue is empty.
- A pop on an empty output queue cannot make the count underflow.

Only the bench scenarios can show bit-exact equality with a direct convolution, and only they cover the overlap carried between segments. The same holds for wraparound on full-scale input and for the claim that stalls, gaps and dropped pushes leave the sample stream intact. The bench checks these by comparing every popped sample with a convolution it computes itself from the accepted inputs.

// File: rtl/ola_fir.sv
module ola_fir #(
  parameter int W         = 12,
  parameter int FRAC      = 11,
  parameter int TAPS      = 4,
  parameter int SEG       = 4,
  parameter int IN_DEPTH  = 8,
  parameter int OUT_DEPTH = 8,
  parameter logic [TAPS*W-1:0] COEF = {12'hEF7, 12'h1CB, 12'h6B1, 12'h3DD}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_push,
  input  logic [W-1:0] in_data,
  output logic         in_full,
  input  logic         out_pop,
  output logic [W-1:0] out_data,
  output logic         out_empty
);
  localparam int AW  = 2*W + $clog2(TAPS) + 1;
  localparam int TOT = SEG + TAPS - 1;
  localparam int IW  = (SEG > 1) ? $clog2(SEG) : 1;
  localparam int JW  = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int KW  = $clog2(TOT + 1);
  localparam int ICW = $clog2(IN_DEPTH + 1);
  localparam int IPW = (IN_DEPTH > 1) ? $clog2(IN_DEPTH) : 1;
  localparam int OCW = $clog2(OUT_DEPTH + 1);
  localparam int OPW = (OUT_DEPTH > 1) ? $clog2(OUT_DEPTH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_COMP, S_EMIT} st_t;
  st_t state;

  logic [W-1:0]   in_mem [IN_DEPTH];
  logic [IPW-1:0] in_wp, in_rp;
  logic [ICW-1:0] in_cnt;
  logic [W-1:0]   out_mem [OUT_DEPTH];
  logic [OPW-1:0] out_wp, out_rp;
  logic [OCW-1:0] out_cnt;

  logic signed [W-1:0]   xreg [SEG];
  logic signed [AW-1:0]  acc  [TOT];
  logic [IW-1:0]         ld_cnt, mi, ecnt;
  logic [JW-1:0]         mj;
  logic signed [W-1:0]   hsel;
  logic signed [2*W-1:0] prod;
  logic [KW-1:0]         widx;
  logic signed [AW-1:0]  acc0;

  wire in_wr  = in_push && !in_full;
  wire in_rd  = (state == S_LOAD) && (in_cnt != '0);
  wire out_wr = (state == S_EMIT) && (out_cnt != OCW'(OUT_DEPTH));
  wire out_rd = out_pop && !out_empty;

  assign in_full   = (in_cnt == ICW'(IN_DEPTH));
  assign out_empty = (out_cnt == '0);
  assign out_data  = out_mem[out_rp];
  assign hsel      = $signed(COEF[mj*W +: W]);
  assign prod      = xreg[mi] * hsel;
  assign widx      = KW'(mi) + KW'(mj);
  assign acc0      = acc[0];

  always_ff @(posedge clk)
    if (in_wr) in_mem[in_wp] <= in_data;

  always_ff @(posedge clk)
    if (out_wr) out_mem[out_wp] <= acc[0][FRAC+W-1:FRAC];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_wp <= '0; in_rp <= '0; in_cnt <= '0;
      out_wp <= '0; out_rp <= '0; out_cnt <= '0;
    end else begin
      if (in_wr) in_wp <= (in_wp == IPW'(IN_DEPTH-1)) ? '0 : in_wp + 1'b1;
      if (in_rd) in_rp <= (in_rp == IPW'(IN_DEPTH-1)) ? '0 : in_rp + 1'b1;
      in_cnt <= in_cnt + ICW'(in_wr) - ICW'(in_rd);
      if (out_wr) out_wp <= (out_wp == OPW'(OUT_DEPTH-1)) ? '0 : out_wp + 1'b1;
      if (out_rd) out_rp <= (out_rp == OPW'(OUT_DEPTH-1)) ? '0 : out_rp + 1'b1;
      out_cnt <= out_cnt + OCW'(out_wr) - OCW'(out_rd);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      ld_cnt <= '0; mi <= '0; mj <= '0; ecnt <= '0;
      for (int k = 0; k < TOT; k++) acc[k] <= '0;
      for (int k = 0; k < SEG; k++) xreg[k] <= '0;
    end else begin
      case (state)
        S_IDLE: state <= S_LOAD;
        S_LOAD:
          if (in_rd) begin
            xreg[ld_cnt] <= $signed(in_mem[in_rp]);
            if (ld_cnt == IW'(SEG-1)) begin
              ld_cnt <= '0;
              state  <= S_COMP;
            end else ld_cnt <= ld_cnt + 1'b1;
          end
        S_COMP: begin
          acc[widx] <= acc[widx] + AW'(prod);
          if (mj == JW'(TAPS-1)) begin
            mj <= '0;
            if (mi == IW'(SEG-1)) begin
              mi    <= '0;
              state <= S_EMIT;
            end else mi <= mi + 1'b1;
          end else mj <= mj + 1'b1;
        end
        S_EMIT:
          if (out_wr) begin
            for (int k = 0; k < TOT-1; k++) acc[k] <= acc[k+1];
            acc[TOT-1] <= '0;
            if (ecnt == IW'(SEG-1)) begin
              ecnt  <= '0;
              state <= S_LOAD;
            end else ecnt <= ecnt + 1'b1;
          end
        default: state <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/ola_fir_chk.sv
module ola_fir_chk #(
  parameter int IN_DEPTH  = 8,
  parameter int OUT_DEPTH = 8,
  parameter int ICW = 4,
  parameter int OCW = 4,
  parameter int IW  = 2,
  parameter int AW  = 27
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_push,
  input logic           in_full,
  input logic           out_pop,
  input logic           out_empty,
  input logic [ICW-1:0] in_cnt,
  input logic [OCW-1:0] out_cnt,
  input logic [1:0]     state,
  input logic [IW-1:0]  ld_cnt,
  input logic [AW-1:0]  acc0
);
  localparam logic [1:0] ST_LOAD = 2'd1;
  localparam logic [1:0] ST_EMIT = 2'd3;

  p_reset_flags_r1: assert property (@(posedge clk)
    !rst_n |=> (out_empty && !in_full));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= ICW'(IN_DEPTH));

  p_full_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_full && in_push && state != ST_LOAD) |=> in_full);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= OCW'(OUT_DEPTH));

  p_emit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EMIT && out_cnt == OCW'(OUT_DEPTH) && !out_pop)
      |=> ($stable(acc0) && state == ST_EMIT));

  p_load_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && in_cnt == '0) |=> ($stable(ld_cnt) && state == ST_LOAD));

  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt == '0) |=> (out_cnt <= OCW'(1)));
endmodule

bind ola_fir ola_fir_chk #(
  .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH),
  .ICW(ICW), .OCW(OCW), .IW(IW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_push(in_push), .in_full(in_full),
  .out_pop(out_pop), .out_empty(out_empty), .in_cnt(in_cnt),
  .out_cnt(out_cnt), .state(state), .ld_cnt(ld_cnt), .acc0(acc0)
);

// File: tb/tb_ola_fir.sv
module tb_ola_fir;
  localparam int W = 12;
  localparam int L = 4;
  localparam int N = 4;

  logic clk = 1'b0, rst_n = 1'b0, in_push = 1'b0, out_pop = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_full, out_empty;
  logic [W-1:0] out_data;

  always #10 clk = ~clk;

  ola_fir dut (
    .clk(clk), .rst_n(rst_n), .in_push(in_push), .in_data(in_data),
    .in_full(in_full), .out_pop(out_pop), .out_data(out_data),
    .out_empty(out_empty)
  );

  int h [N] = '{989, 1713, 459, -265};
  int xs[$];
  int nout = 0, n_chk = 0, n_bad = 0, mode = 0, cyc = 0;
  string tag = "R7";

  task automatic check(bit ok, string r, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int expect_at(int k);
    longint s = 0;
    for (int j = 0; j < N; j++)
      if (k - j >= 0 && k - j < xs.size()) s += longint'(h[j]) * xs[k-j];
    return int'((s >>> 11) & 64'hFFF);
  endfunction

  function automatic int s12(int u);
    return (u >= 2048) ? u - 4096 : u;
  endfunction

  task automatic push_one(int v);
    while (in_full) @(negedge clk);
    in_push = 1'b1;
    in_data = W'(v);
    xs.push_back(v);
    @(negedge clk);
    in_push = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit d;
      int e;
      d = (mode == 0) || (mode == 2 && (cyc % 3 == 0));
      out_pop = d;
      if (d && !out_empty) begin
        e = expect_at(nout);
        check(int'(out_data) == e, tag, int'(out_data), e);
        nout++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", nout, xs.size());
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_empty == 1'b1 && in_full == 1'b0, "R1", {out_empty, in_full}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_empty == 1'b1 && in_full == 1'b0, "R1", {out_empty, in_full}, 2);

    // R7: pops on an empty queue while nothing was pushed
    mode = 0; tag = "R7";
    repeat (10) @(negedge clk);
    check(out_empty == 1'b1, "R7", out_empty, 1);

    // R2: impulses, carried across segment boundaries
    tag = "R2";
    push_one(2047); repeat (6) push_one(0);
    push_one(-2048); repeat (8) push_one(0);

    // R3: full-scale runs that wrap
    tag = "R3";
    repeat (12) push_one(2047);
    repeat (12) push_one(-2048);

    tag = "R2";
    repeat (40) push_one(s12($urandom_range(0, 4095)));

    // R6: input gaps and a sporadic consumer
    tag = "R6"; mode = 2;
    repeat (30) begin
      push_one(s12($urandom_range(0, 4095)));
      repeat ($urandom_range(0, 9)) @(negedge clk);
    end

    // R4/R5: consumer stalled until the input side backs up
    tag = "R5"; mode = 1;
    for (int t = 0; t < 64 && !in_full; t++) push_one(s12($urandom_range(0, 4095)));
    check(in_full == 1'b1, "R4", in_full, 1);
    in_push = 1'b1; in_data = 12'h555;
    @(negedge clk);
    in_push = 1'b0;
    check(in_full == 1'b1, "R4", in_full, 1);
    repeat (20) @(negedge clk);
    check(out_empty == 1'b0, "R5", out_empty, 0);
    tag = "R4"; mode = 0;

    while (xs.size() % L != 0) push_one(0);
    for (int i = 0; i < 5000 && nout < xs.size(); i++) @(negedge clk);
    check(nout == xs.size(), "R5", nout, xs.size());
    repeat (5) @(negedge clk);
    check(out_empty == 1'b1, "R2", out_empty, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule